// File: doc/BRIEF.md
# Operand Specifier Resolver

This block turns one 6-bit operand code of a 16-bit, word-addressed processor into something the execute stage can use. It produces either a value to read or a place to write the result back. The caller samples the eight general registers, the stack pointer, the program counter and the overflow register on its inputs and pulses `start`. The block then fetches any extension word or indirect data through a single-port memory port with a request/ready handshake. When it finishes, it pulses `done` for one cycle. In that cycle it shows the operand value, a write-target descriptor, the extra cycle cost and the updated PC and SP.

One 6-bit space holds every kind of operand: direct registers, register-indirect and indexed memory, the three stack operations, the special registers, extension-word forms and short inline literals. A write aimed at a literal has nowhere to go, so the target is reported as a discard. In skip mode the operand is resolved only far enough to move PC past its extension word. This lets a sequencer step over an instruction whose condition failed.

The caller may pulse `start` only while no resolution is in flight. The result fields are valid only in the cycle in which `done` is high.

Top module: `opr_resolver`

## Requirements
- R1: Codes 0x00 to 0x07 give the value of general register 0 to 7. They report target kind 1 (register) with `tgt_sel` equal to the index, cost 0 and make no memory access.
- R2: Codes 0x08 to 0x0f read memory at the address held in register (code & 7). The value is the data read, the target kind is 3 (memory) and `tgt_addr` is that address. The cost is 0.
- R3: Codes 0x10 to 0x17 first read an extension word at PC and then advance PC by one. They then access memory at (extension word + register (code & 7)) mod 2^16. The cost is 1.
- R4: Code 0x18 (pop) accesses memory at SP and returns SP+1 mod 2^16. Code 0x19 (peek) accesses memory at SP and returns SP unchanged.
- R5: Code 0x1a (push) accesses memory at SP-1 mod 2^16 and returns SP-1. When SP is 0 the access lands at 0xffff.
- R6: Codes 0x1b, 0x1c and 0x1d give the value of SP, PC and the overflow register. They report target kind 2 (special) with `tgt_sel` 0, 1 and 2, cost 0 and make no memory access.
- R7: Code 0x1e reads memory at the extension word. Code 0x1f gives the extension word itself as a value with target kind 0 (discard). Both cost 1 and advance PC by one.
- R8: Codes 0x20 to 0x3f give the value (code - 0x20). They report target kind 0 (discard), cost 0 and make no memory access.
- R9: With `skip` set, only the extension word is fetched (for codes that have one) and PC advances past it. SP stays unchanged, no indirect data is read, the value is 0 and the target kind is 0.
- R10: While `mem_req` is high and `mem_ready` is low, the request and its address stay unchanged on the next cycle. `done` is high for exactly one cycle per resolution. After reset, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a resolution (only while none is in flight) |
| skip | input | 1 | Advance PC only; no stack change, no data read |
| spec | input | 6 | Operand code |
| gpr_flat | input | 128 | General registers, register n in bits [16n+15:16n] |
| sp_in | input | 16 | Stack pointer |
| pc_in | input | 16 | Program counter, pointing at the next extension word |
| ovf_in | input | 16 | Overflow register |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory word address |
| mem_ready | input | 1 | Memory accepts the request; data valid in the same cycle |
| mem_rdata | input | 16 | Memory read data |
| done | output | 1 | One-cycle result strobe |
| value | output | 16 | Operand value |
| tgt_kind | output | 2 | 0 discard, 1 register, 2 special, 3 memory |
| tgt_sel | output | 3 | Register index, or special: 0 SP, 1 PC, 2 overflow |
| tgt_addr | output | 16 | Memory target address (kind 3) |
| ext_cycles | output | 2 | Extra cycles charged (0 or 1) |
| pc_out | output | 16 | PC after any extension fetch |
| sp_out | output | 16 | SP after any stack adjustment |

## Verification
The bench goes after the wrap points. Indexing of the form 0xfff0 plus an extension word must wrap below 0x10000. Popping at SP 0xffff must return SP 0, pushing at SP 0 must access 0xffff, and an extension fetch at PC 0xffff must leave PC at 0. A design that widened the sum or left out the pre-decrement would return the wrong address or stack pointer.

Skip mode is run on an indexed code, a pop, a long literal and a short literal. A design that let the stack adjust or read indirect data while skipping would show a changed SP or an extra memory access. One that forgot to step over the extension word would show the old PC.

Each resolution is repeated with several memory wait states. This exposes an address that drifts while a request waits, and a result taken before the data returns.

// File: rtl/opr_pkg.sv
package opr_pkg;

    localparam int W      = 16;
    localparam int NREG   = 8;
    localparam int SPEC_W = 6;
    localparam int GIDX_W = $clog2(NREG);
    localparam int INL_W  = SPEC_W - 1;

    typedef enum logic [1:0] {
        TK_DISCARD = 2'd0,
        TK_GPR     = 2'd1,
        TK_SPECIAL = 2'd2,
        TK_MEM     = 2'd3
    } tgt_kind_e;

    typedef enum logic [1:0] {
        SA_HOLD = 2'd0,
        SA_INC  = 2'd1,
        SA_DEC  = 2'd2
    } sp_adj_e;

    typedef enum logic [2:0] {
        VS_GPR = 3'd0,
        VS_MEM = 3'd1,
        VS_SP  = 3'd2,
        VS_PC  = 3'd3,
        VS_OVF = 3'd4,
        VS_EXT = 3'd5,
        VS_INL = 3'd6
    } vsrc_e;

    localparam logic [2:0] SEL_SP  = 3'd0;
    localparam logic [2:0] SEL_PC  = 3'd1;
    localparam logic [2:0] SEL_OVF = 3'd2;

    typedef struct packed {
        logic              need_ext;
        logic              need_mem;
        logic              add_ext;
        logic              gpr_base;
        logic              sp_base;
        sp_adj_e           sp_adj;
        tgt_kind_e         kind;
        logic [2:0]        sel;
        vsrc_e             vsrc;
        logic [GIDX_W-1:0] gidx;
        logic [INL_W-1:0]  inl;
    } opr_dec_t;

    function automatic logic [W-1:0] step_addr(logic [W-1:0] a, sp_adj_e adj);
        case (adj)
            SA_INC:  return a + W'(1);
            SA_DEC:  return a - W'(1);
            default: return a;
        endcase
    endfunction

endpackage

// File: rtl/opr_decode.sv
module opr_decode
    import opr_pkg::*;
(
    input  logic [SPEC_W-1:0] code,
    output opr_dec_t          dec
);
    always_comb begin
        dec          = '0;
        dec.sp_adj   = SA_HOLD;
        dec.kind     = TK_DISCARD;
        dec.vsrc     = VS_INL;
        dec.gidx     = code[GIDX_W-1:0];
        dec.inl      = code[INL_W-1:0];
        if (!code[SPEC_W-1]) begin
            case (code[4:3])
                2'b00: begin
                    dec.vsrc = VS_GPR;
                    dec.kind = TK_GPR;
                    dec.sel  = code[2:0];
                end
                2'b01: begin
                    dec.need_mem = 1'b1;
                    dec.gpr_base = 1'b1;
                    dec.vsrc     = VS_MEM;
                    dec.kind     = TK_MEM;
                end
                2'b10: begin
                    dec.need_ext = 1'b1;
                    dec.need_mem = 1'b1;
                    dec.add_ext  = 1'b1;
                    dec.gpr_base = 1'b1;
                    dec.vsrc     = VS_MEM;
                    dec.kind     = TK_MEM;
                end
                default: begin
                    case (code[2:0])
                        3'd0, 3'd1, 3'd2: begin
                            dec.need_mem = 1'b1;
                            dec.sp_base  = 1'b1;
                            dec.vsrc     = VS_MEM;
                            dec.kind     = TK_MEM;
                            if (code[2:0] == 3'd0) dec.sp_adj = SA_INC;
                            if (code[2:0] == 3'd2) dec.sp_adj = SA_DEC;
                        end
                        3'd3: begin
                            dec.vsrc = VS_SP;
                            dec.kind = TK_SPECIAL;
                            dec.sel  = SEL_SP;
                        end
                        3'd4: begin
                            dec.vsrc = VS_PC;
                            dec.kind = TK_SPECIAL;
                            dec.sel  = SEL_PC;
                        end
                        3'd5: begin
                            dec.vsrc = VS_OVF;
                            dec.kind = TK_SPECIAL;
                            dec.sel  = SEL_OVF;
                        end
                        3'd6: begin
                            dec.need_ext = 1'b1;
                            dec.need_mem = 1'b1;
                            dec.add_ext  = 1'b1;
                            dec.vsrc     = VS_MEM;
                            dec.kind     = TK_MEM;
                        end
                        default: begin
                            dec.need_ext = 1'b1;
                            dec.vsrc     = VS_EXT;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/opr_agen.sv
module opr_agen
    import opr_pkg::*;
(
    input  opr_dec_t           dec,
    input  logic               skip_mode,
    input  logic [NREG*W-1:0]  gpr,
    input  logic [W-1:0]       sp,
    input  logic [W-1:0]       pc0,
    input  logic [W-1:0]       ovf,
    input  logic [W-1:0]       ext_word,
    input  logic [W-1:0]       dat_word,
    output logic [W-1:0]       addr,
    output logic [W-1:0]       value,
    output tgt_kind_e          kind,
    output logic [2:0]         sel,
    output logic [W-1:0]       tgt_addr,
    output logic [W-1:0]       sp_next
);
    logic [W-1:0] reg_word;
    logic [W-1:0] base;

    assign reg_word = gpr[dec.gidx*W +: W];

    always_comb begin
        base = '0;
        if (dec.gpr_base)
            base = reg_word;
        else if (dec.sp_base)
            base = (dec.sp_adj == SA_DEC) ? step_addr(sp, SA_DEC) : sp;
        addr = base + (dec.add_ext ? ext_word : '0);
    end

    always_comb begin
        value = '0;
        if (!skip_mode) begin
            case (dec.vsrc)
                VS_GPR:  value = reg_word;
                VS_MEM:  value = dat_word;
                VS_SP:   value = sp;
                VS_PC:   value = pc0;
                VS_OVF:  value = ovf;
                VS_EXT:  value = ext_word;
                default: value = W'(dec.inl);
            endcase
        end
    end

    assign kind     = skip_mode ? TK_DISCARD : dec.kind;
    assign sel      = dec.sel;
    assign tgt_addr = (kind == TK_MEM) ? addr : '0;
    assign sp_next  = skip_mode ? sp : step_addr(sp, dec.sp_adj);
endmodule

// File: rtl/opr_seq.sv
module opr_seq
    import opr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          need_ext,
    input  logic          need_data,
    input  logic [W-1:0]  pc_in,
    input  logic [W-1:0]  data_addr,
    input  logic          mem_ready,
    input  logic [W-1:0]  mem_rdata,
    output logic          idle,
    output logic          mem_req,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  ext_word,
    output logic [W-1:0]  dat_word,
    output logic [W-1:0]  pc_cur,
    output logic          used_ext,
    output logic          done
);
    typedef enum logic [1:0] {S_IDLE, S_EXT, S_DAT, S_FIN} st_e;
    st_e  st;
    logic need_dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            ext_word   <= '0;
            dat_word   <= '0;
            pc_cur     <= '0;
            used_ext   <= 1'b0;
            need_dat_q <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    pc_cur     <= pc_in;
                    used_ext   <= need_ext;
                    need_dat_q <= need_data;
                    ext_word   <= '0;
                    dat_word   <= '0;
                    st <= need_ext ? S_EXT : (need_data ? S_DAT : S_FIN);
                end
                S_EXT: if (mem_ready) begin
                    ext_word <= mem_rdata;
                    pc_cur   <= pc_cur + W'(1);
                    st       <= need_dat_q ? S_DAT : S_FIN;
                end
                S_DAT: if (mem_ready) begin
                    dat_word <= mem_rdata;
                    st       <= S_FIN;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign idle     = (st == S_IDLE);
    assign mem_req  = (st == S_EXT) || (st == S_DAT);
    assign mem_addr = (st == S_EXT) ? pc_cur : data_addr;
    assign done     = (st == S_FIN);
endmodule

// File: rtl/opr_resolver.sv
module opr_resolver
    import opr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 skip,
    input  logic [SPEC_W-1:0]    spec,
    input  logic [NREG*W-1:0]    gpr_flat,
    input  logic [W-1:0]         sp_in,
    input  logic [W-1:0]         pc_in,
    input  logic [W-1:0]         ovf_in,
    output logic                 mem_req,
    output logic [W-1:0]         mem_addr,
    input  logic                 mem_ready,
    input  logic [W-1:0]         mem_rdata,
    output logic                 done,
    output logic [W-1:0]         value,
    output logic [1:0]           tgt_kind,
    output logic [2:0]           tgt_sel,
    output logic [W-1:0]         tgt_addr,
    output logic [1:0]           ext_cycles,
    output logic [W-1:0]         pc_out,
    output logic [W-1:0]         sp_out
);
    logic [SPEC_W-1:0] spec_q;
    logic              skip_q;
    logic [NREG*W-1:0] gpr_q;
    logic [W-1:0]      sp_q, pc0_q, ovf_q;
    logic              idle, used_ext;
    logic [W-1:0]      ext_word, dat_word, data_addr;
    logic [SPEC_W-1:0] spec_sel;
    logic              skip_sel;
    opr_dec_t          dec;
    tgt_kind_e         kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            spec_q <= '0;
            skip_q <= 1'b0;
            gpr_q  <= '0;
            sp_q   <= '0;
            pc0_q  <= '0;
            ovf_q  <= '0;
        end else if (start && idle) begin
            spec_q <= spec;
            skip_q <= skip;
            gpr_q  <= gpr_flat;
            sp_q   <= sp_in;
            pc0_q  <= pc_in;
            ovf_q  <= ovf_in;
        end
    end

    assign spec_sel = idle ? spec : spec_q;
    assign skip_sel = idle ? skip : skip_q;

    opr_decode u_dec (
        .code (spec_sel),
        .dec  (dec)
    );

    opr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .need_ext  (dec.need_ext),
        .need_data (dec.need_mem && !skip_sel),
        .pc_in     (pc_in),
        .data_addr (data_addr),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .idle      (idle),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .ext_word  (ext_word),
        .dat_word  (dat_word),
        .pc_cur    (pc_out),
        .used_ext  (used_ext),
        .done      (done)
    );

    opr_agen u_agen (
        .dec       (dec),
        .skip_mode (skip_sel),
        .gpr       (gpr_q),
        .sp        (sp_q),
        .pc0       (pc0_q),
        .ovf       (ovf_q),
        .ext_word  (ext_word),
        .dat_word  (dat_word),
        .addr      (data_addr),
        .value     (value),
        .kind      (kind),
        .sel       (tgt_sel),
        .tgt_addr  (tgt_addr),
        .sp_next   (sp_out)
    );

    assign tgt_kind   = kind;
    assign ext_cycles = {1'b0, used_ext};
endmodule

// File: rtl/opr_resolver_chk.sv
module opr_resolver_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        skip,
    input logic [5:0]  spec,
    input logic [15:0] sp_in,
    input logic [15:0] pc_in,
    input logic        mem_req,
    input logic [15:0] mem_addr,
    input logic        mem_ready,
    input logic        done,
    input logic [1:0]  tgt_kind,
    input logic [2:0]  tgt_sel,
    input logic [1:0]  ext_cycles,
    input logic [15:0] pc_out,
    input logic [15:0] sp_out
);
    logic        busy_c;
    logic [5:0]  rec_spec;
    logic        rec_skip;
    logic [15:0] rec_sp, rec_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_c   <= 1'b0;
            rec_spec <= '0;
            rec_skip <= 1'b0;
            rec_sp   <= '0;
            rec_pc   <= '0;
        end else if (!busy_c && start) begin
            busy_c   <= 1'b1;
            rec_spec <= spec;
            rec_skip <= skip;
            rec_sp   <= sp_in;
            rec_pc   <= pc_in;
        end else if (done) begin
            busy_c <= 1'b0;
        end
    end

    a_r10_addr_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_req_in_flight: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy_c);

    a_r8_literal_discard: assert property (@(posedge clk) disable iff (rst)
        done && rec_spec >= 6'h1f |-> tgt_kind == 2'd0);

    a_r9_skip_keeps_sp: assert property (@(posedge clk) disable iff (rst)
        done && rec_skip |-> sp_out == rec_sp && tgt_kind == 2'd0);

    a_r3_pc_advance: assert property (@(posedge clk) disable iff (rst)
        done |-> pc_out == rec_pc + {14'd0, ext_cycles});

    a_r6_special_sel: assert property (@(posedge clk) disable iff (rst)
        done && !rec_skip && rec_spec >= 6'h1b && rec_spec <= 6'h1d
        |-> tgt_kind == 2'd2 && {3'd0, tgt_sel} == rec_spec - 6'h1b);
endmodule

bind opr_resolver opr_resolver_chk u_chk (.*);

// File: tb/tb_opr_resolver.sv
`timescale 1ns/1ps
module tb_opr_resolver;
    logic         clk = 1'b0;
    logic         rst, start, skip;
    logic [5:0]   spec;
    logic [127:0] gpr_flat;
    logic [15:0]  sp_in, pc_in, ovf_in;
    logic         mem_req, mem_ready;
    logic [15:0]  mem_addr, mem_rdata;
    logic         done;
    logic [15:0]  value, tgt_addr, pc_out, sp_out;
    logic [1:0]   tgt_kind, ext_cycles;
    logic [2:0]   tgt_sel;

    always #2.5 clk = ~clk;

    opr_resolver dut (.*);

    typedef struct {
        logic [15:0] val;
        logic [1:0]  kind;
        logic [2:0]  sel;
        logic [15:0] addr;
        logic [1:0]  cyc;
        logic [15:0] pc;
        logic [15:0] sp;
        int          acc;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    exp_t        e;
    int          n_chk = 0, n_fail = 0;
    int          acc_cnt = 0, wait_cfg = 0, wcnt = 0;
    logic [15:0] rf [8];
    logic [15:0] sp_v, pc_v, o_v;

    function automatic logic [15:0] mem_fn(logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h0f0f;
    endfunction

    // memory model with configurable wait states
    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
            end else if (mem_req) begin
                if (wcnt >= wait_cfg) begin
                    mem_ready = 1'b1;
                    mem_rdata = mem_fn(mem_addr);
                    acc_cnt++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // monitor: compares results against the scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            n_chk++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL R10: unexpected done, got 1 expected 0");
            end else begin
                e = sbq.pop_front();
                if (value !== e.val || tgt_kind !== e.kind || ext_cycles !== e.cyc ||
                    pc_out !== e.pc || sp_out !== e.sp || acc_cnt != e.acc ||
                    ((e.kind == 2'd1 || e.kind == 2'd2) && tgt_sel !== e.sel) ||
                    (e.kind == 2'd3 && tgt_addr !== e.addr)) begin
                    n_fail++;
                    $display("FAIL %s: got val=%h kind=%0d sel=%0d addr=%h cyc=%0d pc=%h sp=%h acc=%0d; expected val=%h kind=%0d sel=%0d addr=%h cyc=%0d pc=%h sp=%h acc=%0d",
                        e.tag, value, tgt_kind, tgt_sel, tgt_addr, ext_cycles, pc_out, sp_out, acc_cnt,
                        e.val, e.kind, e.sel, e.addr, e.cyc, e.pc, e.sp, e.acc);
                end
            end
        end
    end

    task automatic run_op(input logic [5:0] c, input logic sk, input int wt, input string tag);
        exp_t        x;
        logic [15:0] ext;
        logic        has_ext, has_mem;
        ext     = mem_fn(pc_v);
        has_ext = (c >= 6'h10 && c <= 6'h17) || c == 6'h1e || c == 6'h1f;
        has_mem = (c >= 6'h08 && c <= 6'h1a) || c == 6'h1e;
        x.tag   = tag;
        x.sel   = '0;
        x.addr  = '0;
        x.cyc   = has_ext ? 2'd1 : 2'd0;
        x.pc    = has_ext ? pc_v + 16'd1 : pc_v;
        x.sp    = sp_v;
        x.val   = '0;
        x.kind  = 2'd0;
        if (c < 6'h08) begin
            x.val = rf[c[2:0]]; x.kind = 2'd1; x.sel = c[2:0];
        end else if (c < 6'h10) begin
            x.addr = rf[c[2:0]]; x.kind = 2'd3;
        end else if (c < 6'h18) begin
            x.addr = ext + rf[c[2:0]]; x.kind = 2'd3;
        end else if (c == 6'h18) begin
            x.addr = sp_v; x.kind = 2'd3; x.sp = sp_v + 16'd1;
        end else if (c == 6'h19) begin
            x.addr = sp_v; x.kind = 2'd3;
        end else if (c == 6'h1a) begin
            x.addr = sp_v - 16'd1; x.kind = 2'd3; x.sp = sp_v - 16'd1;
        end else if (c == 6'h1b) begin
            x.val = sp_v; x.kind = 2'd2; x.sel = 3'd0;
        end else if (c == 6'h1c) begin
            x.val = pc_v; x.kind = 2'd2; x.sel = 3'd1;
        end else if (c == 6'h1d) begin
            x.val = o_v; x.kind = 2'd2; x.sel = 3'd2;
        end else if (c == 6'h1e) begin
            x.addr = ext; x.kind = 2'd3;
        end else if (c == 6'h1f) begin
            x.val = ext;
        end else begin
            x.val = {10'd0, c - 6'h20};
        end
        if (x.kind == 2'd3) x.val = mem_fn(x.addr);
        x.acc = (has_ext ? 1 : 0) + ((has_mem && !sk) ? 1 : 0);
        if (sk) begin
            x.val = '0; x.kind = 2'd0; x.sp = sp_v;
        end
        sbq.push_back(x);
        @(negedge clk);
        wait_cfg = wt;
        acc_cnt  = 0;
        spec     = c;
        skip     = sk;
        for (int i = 0; i < 8; i++) gpr_flat[i*16 +: 16] = rf[i];
        sp_in    = sp_v;
        pc_in    = pc_v;
        ovf_in   = o_v;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        n_chk++;
        if (done !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: done held, got %b expected 0", done);
        end
    endtask

    task automatic run_all();
        rst = 1'b1; start = 1'b0; skip = 1'b0; spec = '0; gpr_flat = '0;
        sp_in = '0; pc_in = '0; ovf_in = '0;
        rf[0] = 16'h1111; rf[1] = 16'h2222; rf[2] = 16'h1000; rf[3] = 16'h0042;
        rf[4] = 16'hffff; rf[5] = 16'h8000; rf[6] = 16'hfff0; rf[7] = 16'h0007;
        sp_v = 16'hfffe; pc_v = 16'h0100; o_v = 16'hbeef;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (done !== 1'b0 || mem_req !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: reset state done=%b req=%b expected 0 0", done, mem_req);
        end
        run_op(6'h03, 1'b0, 0, "R1");
        run_op(6'h07, 1'b0, 0, "R1");
        run_op(6'h0a, 1'b0, 2, "R2");
        run_op(6'h0c, 1'b0, 0, "R2");
        run_op(6'h16, 1'b0, 1, "R3");
        run_op(6'h11, 1'b0, 0, "R3");
        sp_v = 16'hffff;
        run_op(6'h18, 1'b0, 0, "R4");
        run_op(6'h19, 1'b0, 2, "R4");
        sp_v = 16'h0000;
        run_op(6'h1a, 1'b0, 1, "R5");
        sp_v = 16'h4000;
        run_op(6'h1a, 1'b0, 0, "R5");
        run_op(6'h1b, 1'b0, 0, "R6");
        run_op(6'h1c, 1'b0, 0, "R6");
        run_op(6'h1d, 1'b0, 0, "R6");
        run_op(6'h1e, 1'b0, 3, "R7");
        run_op(6'h1f, 1'b0, 0, "R7");
        run_op(6'h20, 1'b0, 0, "R8");
        run_op(6'h3f, 1'b0, 0, "R8");
        run_op(6'h12, 1'b1, 1, "R9");
        run_op(6'h18, 1'b1, 0, "R9");
        run_op(6'h3f, 1'b1, 0, "R9");
        run_op(6'h1f, 1'b1, 2, "R9");
        pc_v = 16'hffff;
        run_op(6'h1e, 1'b0, 4, "R10");
        run_op(6'h15, 1'b0, 3, "R10");
        repeat (2) @(negedge clk);
        n_chk++;
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL R10: missing results, got %0d pending expected 0", sbq.size());
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL R10: watchdog expired, got hang expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule